// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block sits in the decode stage of a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. It decides in each cycle whether the instruction now in decode may move on to execute. The decision depends on what the bypass network can deliver. Results of ordinary ALU operations can be forwarded from the memory and writeback stages into execute. A load result becomes usable only from writeback, so it cannot be forwarded out of the memory stage. Branches compare their operands in decode and can take a value forwarded only from the memory stage, and only if that value did not come from a load.

The controller reads three things: the full instruction word held in the fetch/decode register, the opcode and destination held in the decode/execute register, and the opcode and destination held in the execute/memory register. From these alone it produces three outputs with no clock involved. On a hazard it holds the program counter and the fetch/decode register, and it turns the slot entering execute into a no-op. The instruction after a branch sits in a delay slot and always runs, so the controller never squashes it.

Opcodes used: register-register 6'h00 (destination in bits 15:11), jump 6'h02, branch-if-equal 6'h04, load 6'h23 (destination in bits 20:16), store 6'h2B. The first source register is in bits 25:21 and the second in bits 20:16. Any other opcode is an immediate-form operation that reads only the first source.

Top module: `hazard_stall_ctl`

## Requirements
- R1: When the decode instruction reads a register and the instruction in execute is a load (6'h23) whose destination is that same nonzero register, the controller stalls.
- R2: Which source fields count as read depends on the decode opcode. The first source is read by every opcode except jump (6'h02). The second source is read only by register-register (6'h00), branch (6'h04) and store (6'h2B). A match on a field that is not read causes no stall.
- R3: A branch (6'h04) in decode whose first or second source matches the nonzero destination of the instruction in execute stalls, whatever that instruction's opcode.
- R4: A branch in decode whose source matches the nonzero destination of a load in the memory stage stalls.
- R5: A branch in decode whose source matches the destination of a non-load in the memory stage does not stall, because that value is forwarded.
- R6: A non-branch in decode does not stall on a non-load in execute, and never stalls on any instruction in the memory stage.
- R7: Register zero as a destination never causes a stall.
- R8: Without a stall the outputs are pc_write=1, ifid_write=1, id_ex_bubble=0. With a stall they are pc_write=0, ifid_write=0, id_ex_bubble=1.
- R9: In a pipeline using this controller, the sequence load, load, add of both loads, add using that sum, branch on both sums, delay-slot add reaches its last writeback in cycle 12 with exactly 2 stall cycles. The delay-slot instruction is not squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_instr | input | 32 | Instruction word in the fetch/decode register |
| ex_op | input | 6 | Opcode in the decode/execute register |
| ex_rd | input | 5 | Destination in the decode/execute register (0 when none) |
| mem_op | input | 6 | Opcode in the execute/memory register |
| mem_rd | input | 5 | Destination in the execute/memory register (0 when none) |
| pc_write | output | 1 | Program counter update enable, active high |
| ifid_write | output | 1 | Fetch/decode register load enable, active high |
| id_ex_bubble | output | 1 | Replace the slot entering execute with a no-op |

## Verification
The bench targets four kinds of mistake.

- **Unread source fields.** A load or immediate in decode whose unread second field equals a pending load's destination must not stall. A controller that ignores which fields are read would stall there for no reason. A jump whose target bits look like a register must not stall either.
- **Branch after a load.** A branch that follows a load directly must stall twice: once with the load in execute and again with the load in memory. A design that relies on memory-stage forwarding for loads would let the branch compare stale data after one stall.
- **Forwardable ALU results.** The bench checks that such results do not stall, so a design that stalls too often is caught.
- **Register zero.** Destination zero must never stall.

Finally, the two replayed sequences detect any extra or missing stall through their total cycle counts.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int REG_W   = 5;
  localparam int OP_LSB  = INSTR_W - OP_W;
  localparam int RS_LSB  = OP_LSB - REG_W;
  localparam int RT_LSB  = RS_LSB - REG_W;

  typedef logic [OP_W-1:0]    op_t;
  typedef logic [REG_W-1:0]   reg_t;
  typedef logic [INSTR_W-1:0] instr_t;

  localparam op_t OP_RR   = 6'h00;
  localparam op_t OP_JUMP = 6'h02;
  localparam op_t OP_BEQ  = 6'h04;
  localparam op_t OP_LOAD = 6'h23;
  localparam op_t OP_STOR = 6'h2B;

  // first source field is a real operand for everything but a jump
  function automatic logic reads_src_a(input op_t op);
    return op != OP_JUMP;
  endfunction

  // second source field is an operand only for these three formats
  function automatic logic reads_src_b(input op_t op);
    return (op == OP_RR) || (op == OP_BEQ) || (op == OP_STOR);
  endfunction

  // a real dependency needs a used source and a nonzero matching target
  function automatic logic dep_hit(input reg_t src, input logic used, input reg_t dst);
    return used && (dst != '0) && (src == dst);
  endfunction
endpackage

// File: rtl/hzc_decode.sv
module hzc_decode
  import hzc_pkg::*;
(
  input  logic [INSTR_W-1:RT_LSB] instr_hi,
  output op_t                     op,
  output reg_t                    src_a,
  output reg_t                    src_b,
  output logic                    src_a_used,
  output logic                    src_b_used,
  output logic                    is_branch
);
  assign op         = instr_hi[INSTR_W-1:OP_LSB];
  assign src_a      = instr_hi[OP_LSB-1:RS_LSB];
  assign src_b      = instr_hi[RS_LSB-1:RT_LSB];
  assign src_a_used = reads_src_a(op);
  assign src_b_used = reads_src_b(op);
  assign is_branch  = (op == OP_BEQ);
endmodule

// File: rtl/hzc_load_use.sv
module hzc_load_use
  import hzc_pkg::*;
(
  input  reg_t src_a,
  input  reg_t src_b,
  input  logic src_a_used,
  input  logic src_b_used,
  input  op_t  ex_op,
  input  reg_t ex_rd,
  output logic hit
);
  logic ex_is_load;
  assign ex_is_load = (ex_op == OP_LOAD);
  assign hit = ex_is_load &&
               (dep_hit(src_a, src_a_used, ex_rd) || dep_hit(src_b, src_b_used, ex_rd));
endmodule

// File: rtl/hzc_branch_dep.sv
module hzc_branch_dep
  import hzc_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic                       is_branch,
  input  logic [NSRC-1:0][REG_W-1:0] srcs,
  input  logic [NSRC-1:0]            used,
  input  reg_t                       ex_rd,
  input  op_t                        mem_op,
  input  reg_t                       mem_rd,
  output logic                       ex_hit,
  output logic                       mem_hit
);
  logic [NSRC-1:0] ex_m, mem_m;
  logic            mem_is_load;

  assign mem_is_load = (mem_op == OP_LOAD);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    // execute-stage result is never ready for a decode-stage compare
    assign ex_m[g]  = dep_hit(srcs[g], used[g], ex_rd);
    // memory-stage result is forwardable unless it comes from a load
    assign mem_m[g] = mem_is_load && dep_hit(srcs[g], used[g], mem_rd);
  end

  assign ex_hit  = is_branch && (|ex_m);
  assign mem_hit = is_branch && (|mem_m);
endmodule

// File: rtl/hazard_stall_ctl.sv
module hazard_stall_ctl
  import hzc_pkg::*;
(
  input  logic [31:0] id_instr,
  input  logic [5:0]  ex_op,
  input  logic [4:0]  ex_rd,
  input  logic [5:0]  mem_op,
  input  logic [4:0]  mem_rd,
  output logic        pc_write,
  output logic        ifid_write,
  output logic        id_ex_bubble
);
  op_t  dec_op;
  reg_t dec_a, dec_b;
  logic dec_a_used, dec_b_used, dec_branch;
  logic load_use_hit, br_ex_hit, br_mem_hit, stall;
  wire  unused_low_bits = ^id_instr[RT_LSB-1:0];

  hzc_decode u_dec (
    .instr_hi   (id_instr[INSTR_W-1:RT_LSB]),
    .op         (dec_op),
    .src_a      (dec_a),
    .src_b      (dec_b),
    .src_a_used (dec_a_used),
    .src_b_used (dec_b_used),
    .is_branch  (dec_branch)
  );

  hzc_load_use u_lu (
    .src_a      (dec_a),
    .src_b      (dec_b),
    .src_a_used (dec_a_used),
    .src_b_used (dec_b_used),
    .ex_op      (ex_op),
    .ex_rd      (ex_rd),
    .hit        (load_use_hit)
  );

  hzc_branch_dep #(.NSRC(2)) u_br (
    .is_branch (dec_branch),
    .srcs      ({dec_b, dec_a}),
    .used      ({dec_b_used, dec_a_used}),
    .ex_rd     (ex_rd),
    .mem_op    (mem_op),
    .mem_rd    (mem_rd),
    .ex_hit    (br_ex_hit),
    .mem_hit   (br_mem_hit)
  );

  assign stall        = load_use_hit | br_ex_hit | br_mem_hit;
  assign pc_write     = ~stall;
  assign ifid_write   = ~stall;
  assign id_ex_bubble = stall;
endmodule

// File: rtl/hazard_stall_ctl_chk.sv
module hazard_stall_ctl_chk
  import hzc_pkg::*;
(
  input logic [31:0] id_instr,
  input logic [5:0]  ex_op,
  input logic [4:0]  ex_rd,
  input logic [5:0]  mem_op,
  input logic [4:0]  mem_rd,
  input logic        pc_write,
  input logic        ifid_write,
  input logic        id_ex_bubble,
  input logic        load_use_hit,
  input logic        br_ex_hit,
  input logic        br_mem_hit
);
  op_t  c_op;
  reg_t c_rs, c_rt;
  assign c_op = id_instr[INSTR_W-1:OP_LSB];
  assign c_rs = id_instr[OP_LSB-1:RS_LSB];
  assign c_rt = id_instr[RS_LSB-1:RT_LSB];

  always_comb begin
    a_r1_load_use_cause: assert (!load_use_hit ||
      (ex_op == OP_LOAD && ex_rd != '0 && (c_rs == ex_rd || c_rt == ex_rd)))
      else $error("load-use flag without a pending load dependency");
    a_r3_branch_ex_cause: assert (!br_ex_hit || (c_op == OP_BEQ && ex_rd != '0))
      else $error("branch/execute flag without a branch on a real target");
    a_r4_branch_mem_load: assert (!br_mem_hit || (c_op == OP_BEQ && mem_op == OP_LOAD))
      else $error("branch/memory flag without a load in memory");
    a_r6_nonbranch_alu: assert (!(c_op != OP_BEQ && ex_op != OP_LOAD) || !id_ex_bubble)
      else $error("non-branch stalled with no load in execute");
    a_r7_zero_dest: assert (!(ex_rd == '0 && mem_rd == '0) || !id_ex_bubble)
      else $error("stall with only register zero targets");
    a_r8_output_pair: assert (pc_write == ifid_write && id_ex_bubble != pc_write)
      else $error("hold and bubble outputs disagree");
  end
endmodule

bind hazard_stall_ctl hazard_stall_ctl_chk u_chk (.*);

// File: tb/sim_hazard_stall_ctl.sv
`timescale 1ns/1ps
module sim_hazard_stall_ctl;
  import hzc_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] id_instr;
  logic [5:0]  ex_op, mem_op;
  logic [4:0]  ex_rd, mem_rd;
  logic        pc_write, ifid_write, id_ex_bubble;

  hazard_stall_ctl u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt);
    return {op, rs[4:0], rt[4:0], 16'h0064};
  endfunction
  function automatic logic [58:0] mkv(logic [31:0] ins, logic [5:0] eo, int er,
                                      logic [5:0] mo, int mr, bit st, int rq);
    return {ins, eo, er[4:0], mo, mr[4:0], st, rq[3:0]};
  endfunction

  localparam int NV = 15;
  localparam logic [58:0] VEC [NV] = '{
    mkv(enc_r(1,2,3),     6'h23, 2, 6'h00, 0, 1, 1), // R1 second source from load
    mkv(enc_r(1,2,3),     6'h23, 1, 6'h00, 0, 1, 1), // R1 first source from load
    mkv(enc_i(6'h23,1,5), 6'h23, 5, 6'h00, 0, 0, 2), // R2 load ignores field b
    mkv(enc_i(6'h2B,1,5), 6'h23, 5, 6'h00, 0, 1, 2), // R2 store reads field b
    mkv(enc_i(6'h02,1,0), 6'h23, 1, 6'h00, 0, 0, 2), // R2 jump reads nothing
    mkv(enc_i(6'h08,1,7), 6'h23, 7, 6'h00, 0, 0, 2), // R2 immediate ignores field b
    mkv(enc_i(6'h08,1,7), 6'h23, 1, 6'h00, 0, 1, 2), // R2 immediate reads field a
    mkv(enc_i(6'h04,3,4), 6'h00, 4, 6'h00, 0, 1, 3), // R3 branch on ALU in execute
    mkv(enc_i(6'h04,3,4), 6'h23, 3, 6'h00, 0, 1, 3), // R3 branch on load in execute
    mkv(enc_i(6'h04,1,2), 6'h00, 0, 6'h23, 2, 1, 4), // R4 branch on load in memory
    mkv(enc_i(6'h04,1,2), 6'h00, 0, 6'h00, 1, 0, 5), // R5 branch on ALU in memory
    mkv(enc_r(1,2,3),     6'h00, 1, 6'h00, 0, 0, 6), // R6 ALU forwarded in execute
    mkv(enc_r(1,2,3),     6'h00, 0, 6'h23, 1, 0, 6), // R6 memory load ignored
    mkv(enc_r(0,2,3),     6'h23, 0, 6'h00, 0, 0, 7), // R7 load into zero
    mkv(enc_i(6'h04,0,0), 6'h00, 0, 6'h23, 0, 0, 7)  // R7 branch on zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // pipeline replay model driven by the controller outputs
  logic [31:0] prog [8];
  int plen;

  function automatic logic [4:0] dest_of(logic [31:0] ins);
    if (ins[31:26] == 6'h00) return ins[15:11];
    if (ins[31:26] == 6'h23) return ins[20:16];
    return 5'd0;
  endfunction

  task automatic replay(output int cycles, output int stalls, output bit last_done);
    int pc = 0, ifid_idx = -1, ex_idx = -1, mem_idx = -1, wb_idx = -1;
    cycles = 1; stalls = 0; last_done = 0;
    id_instr = 32'd0; ex_op = 6'd0; ex_rd = 5'd0; mem_op = 6'd0; mem_rd = 5'd0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (wb_idx == plen - 1) begin last_done = 1; break; end
      if (id_ex_bubble) stalls++;
      wb_idx = mem_idx;
      mem_idx = ex_idx; mem_op = ex_op; mem_rd = ex_rd;
      if (id_ex_bubble) begin
        ex_idx = -1; ex_op = 6'd0; ex_rd = 5'd0;
      end else begin
        ex_idx = ifid_idx; ex_op = id_instr[31:26]; ex_rd = dest_of(id_instr);
      end
      if (ifid_write) begin
        if (pc < plen) begin id_instr = prog[pc]; ifid_idx = pc; end
        else begin id_instr = 32'd0; ifid_idx = -1; end
      end
      if (pc_write) pc++;
      cycles++;
    end
  endtask

  initial begin
    int cyc, stl;
    bit fin;
    // reset state: empty pipeline
    id_instr = 32'd0; ex_op = 6'd0; ex_rd = 5'd0; mem_op = 6'd0; mem_rd = 5'd0;
    @(negedge clk); #1;
    chk("R8 reset outputs", {pc_write, ifid_write, id_ex_bubble}, 3'b110);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {id_instr, ex_op, ex_rd, mem_op, mem_rd} = VEC[i][58:5];
      #1;
      chk($sformatf("R%0d/R8 vector %0d", VEC[i][3:0], i),
          {pc_write, ifid_write, id_ex_bubble},
          VEC[i][4] ? 3'b001 : 3'b110);
    end

    // R9 dependent sequence
    prog[0] = enc_i(6'h23, 0, 1);
    prog[1] = enc_i(6'h23, 0, 2);
    prog[2] = enc_r(1, 2, 3);
    prog[3] = enc_r(3, 1, 4);
    prog[4] = enc_i(6'h04, 3, 4);
    prog[5] = enc_r(4, 4, 4);
    plen = 6;
    replay(cyc, stl, fin);
    chk("R9 total cycles", cyc, 12);
    chk("R9 stall cycles", stl, 2);
    chk("R9 delay slot retired", {31'd0, fin}, 1);

    // R4 branch right after a load: two stalls
    prog[0] = enc_i(6'h23, 0, 1);
    prog[1] = enc_i(6'h04, 1, 0);
    prog[2] = enc_r(2, 2, 2);
    plen = 3;
    replay(cyc, stl, fin);
    chk("R4 load-branch cycles", cyc, 9);
    chk("R4 load-branch stalls", stl, 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule